// File: doc/BRIEF.md
# Three-Channel Prescaled Down-Counter Timer

This block is a bus-programmable timer with three independent 32-bit down-counting channels. Each channel has a reload value, a live counter and a control word. The control word selects one of four clock divisions, enables the interrupt, holds a sticky underflow flag and stores a count-edge select bit. One shared run register holds a single enable bit per channel. Software programs a reload value and a start count. It picks a division and sets the channel's run bit. The channel then decrements once per divided tick. When a tick arrives while the counter is zero, the counter reloads and the flag is raised.

The divided ticks come from a single free-running prescaler counter that all channels share. Each channel takes a one-cycle count enable from the tap it selects. Every channel drives its own interrupt line. The line is high whenever that channel's flag and interrupt enable are both set. The flag stays set until software writes a zero to it.

Top module: `ptmr_top`

## Requirements
- R1: After reset the run register and every control word read 0, every counter and reload register reads 0xFFFFFFFF, and all interrupt lines are low.
- R2: Channel n's counter changes only while bit n of the run register (address 0, bits [2:0]) is 1 or when software writes the counter; a cleared bit freezes the count.
- R3: The division select in control bits [1:0] (0, 1, 2, 3) makes the counter step once every 4, 16, 64 or 256 clock cycles, so with reload value C the underflow events of a running channel are exactly div*(C+1) cycles apart.
- R4: When a count enable arrives with the counter at 0, the counter loads the reload value and the underflow flag (control bit 4) becomes 1 in that same cycle.
- R5: Interrupt line n is high exactly when channel n's underflow flag and interrupt enable (control bit 3) are both 1.
- R6: Writing 0 to control bit 4 clears the flag; writing 1 there leaves it unchanged and never sets it; an underflow in the same cycle as a clearing write wins.
- R7: A write to the reload register leaves the running count undisturbed and is used from the next reload onward.
- R8: A write to the counter register loads it directly and overrides any count step in that cycle.
- R9: Control bit 2 is the count-edge select; it is stored and read back, and its value 0 (the reset value) means counting on the rising clock edge.
- R10: Channel n's registers sit at word address 4*(n+1) plus 0 (reload), 1 (counter) or 2 (control); other addresses and unused bits read as 0.
- R11: The channels are independent: one channel running and underflowing does not change another channel's count or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
The hardest case to reach from the ports is the exact placement of an underflow. The prescaler runs freely from reset, so the phase of the first tick after a start is not known to software. The bench therefore measures the cycle distance between two consecutive interrupt edges. It clears the flag in between, and that distance does not depend on phase. The bench also reads the counter in the cycle right after the interrupt edge, which shows the reload happened in the same cycle. The deferred reload is reached by rewriting the reload register while a long count is still in progress, then timing the following period.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int NUM_DIV = 4;              // selectable divisions
    localparam int DIV_STEP = 2;             // log2 ratio between taps
    localparam int PRE_W = NUM_DIV * DIV_STEP;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // control word, bit 4 down to bit 0
    typedef struct packed {
        logic       flag;
        logic       irq_en;
        logic       edge_sel;
        logic [1:0] div_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // tap k fires when the low 2*(k+1) prescaler bits are all ones
    function automatic logic tap_hit(input logic [PRE_W-1:0] pre, input int k);
        logic [PRE_W-1:0] mask;
        mask = PRE_W'((1 << (DIV_STEP * (k + 1))) - 1);
        return (pre & mask) == mask;
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [NUM_DIV-1:0] ticks
);
    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PRE_W'(1);
    end

    for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
        assign ticks[k] = tap_hit(pre_q, k);
    end
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [NUM_DIV-1:0] ticks,
    input  logic               wr_reload,
    input  logic               wr_count,
    input  logic               wr_ctrl,
    input  logic [CW-1:0]      wdata,
    output logic [CW-1:0]      count_q,
    output logic [CW-1:0]      reload_q,
    output ctrl_t              ctrl_q,
    output logic               irq
);
    logic step;
    logic at_zero;
    logic uflow;

    assign step    = run && ticks[ctrl_q.div_sel];
    assign at_zero = (count_q == '0);
    assign uflow   = step && at_zero && !wr_count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '1;
            reload_q <= '1;
            ctrl_q   <= '0;
        end else begin
            if (wr_reload) reload_q <= wdata;

            if (wr_count)     count_q <= wdata;
            else if (step)    count_q <= at_zero ? reload_q : count_q - CW'(1);

            if (wr_ctrl) begin
                ctrl_q.div_sel  <= wdata[1:0];
                ctrl_q.edge_sel <= wdata[2];
                ctrl_q.irq_en   <= wdata[3];
            end

            if (uflow)                   ctrl_q.flag <= 1'b1;
            else if (wr_ctrl && !wdata[4]) ctrl_q.flag <= 1'b0;
        end
    end

    assign irq = ctrl_q.flag && ctrl_q.irq_en;
endmodule

// File: rtl/ptmr_bus.sv
module ptmr_bus
    import ptmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 32,
    parameter int AW  = 4
) (
    input  logic [AW-1:0]           addr,
    input  logic                    we,
    input  logic [NCH-1:0]          start_q,
    input  logic [NCH-1:0][CW-1:0]  count_v,
    input  logic [NCH-1:0][CW-1:0]  reload_v,
    input  ctrl_t [NCH-1:0]         ctrl_v,
    output logic                    wr_start,
    output logic [NCH-1:0]          wr_reload,
    output logic [NCH-1:0]          wr_count,
    output logic [NCH-1:0]          wr_ctrl,
    output logic [CW-1:0]           rdata
);
    localparam int BW = AW - 2;

    logic [BW-1:0] blk;
    reg_sel_e      sel;

    assign blk = addr[AW-1:2];
    assign sel = reg_sel_e'(addr[1:0]);

    always_comb begin
        wr_start  = we && (addr == '0);
        wr_reload = '0;
        wr_count  = '0;
        wr_ctrl   = '0;
        rdata     = '0;
        if (addr == '0) rdata = CW'(start_q);
        for (int i = 0; i < NCH; i++) begin
            if (blk == BW'(i + 1)) begin
                unique case (sel)
                    SEL_RELOAD: begin
                        wr_reload[i] = we;
                        rdata        = reload_v[i];
                    end
                    SEL_COUNT: begin
                        wr_count[i] = we;
                        rdata       = count_v[i];
                    end
                    SEL_CTRL: begin
                        wr_ctrl[i] = we;
                        rdata      = CW'(ctrl_v[i]);
                    end
                    default: rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 32,
    parameter int AW  = $clog2(NCH + 1) + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    input  logic           bus_we,
    output logic [CW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    logic [NUM_DIV-1:0]     ticks;
    logic [NCH-1:0]         start_q;
    logic                   wr_start;
    logic [NCH-1:0]         wr_reload;
    logic [NCH-1:0]         wr_count;
    logic [NCH-1:0]         wr_ctrl;
    logic [NCH-1:0][CW-1:0] count_v;
    logic [NCH-1:0][CW-1:0] reload_v;
    ctrl_t [NCH-1:0]        ctrl_v;
    logic [NCH-1:0]         flag_v;

    ptmr_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .ticks (ticks)
    );

    always_ff @(posedge clk) begin
        if (rst)           start_q <= '0;
        else if (wr_start) start_q <= bus_wdata[NCH-1:0];
    end

    ptmr_bus #(.NCH(NCH), .CW(CW), .AW(AW)) u_bus (
        .addr      (bus_addr),
        .we        (bus_we),
        .start_q   (start_q),
        .count_v   (count_v),
        .reload_v  (reload_v),
        .ctrl_v    (ctrl_v),
        .wr_start  (wr_start),
        .wr_reload (wr_reload),
        .wr_count  (wr_count),
        .wr_ctrl   (wr_ctrl),
        .rdata     (bus_rdata)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        ptmr_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .run       (start_q[n]),
            .ticks     (ticks),
            .wr_reload (wr_reload[n]),
            .wr_count  (wr_count[n]),
            .wr_ctrl   (wr_ctrl[n]),
            .wdata     (bus_wdata),
            .count_q   (count_v[n]),
            .reload_q  (reload_v[n]),
            .ctrl_q    (ctrl_v[n]),
            .irq       (irq[n])
        );
        assign flag_v[n] = ctrl_v[n].flag;
    end
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
    parameter int NCH = 3,
    parameter int CW  = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         start_q,
    input logic [NCH-1:0][CW-1:0] count_v,
    input logic [NCH-1:0][CW-1:0] reload_v,
    input logic [NCH-1:0]         flag_v,
    input logic [NCH-1:0]         wr_count
);
    localparam logic [CW-1:0] ONE = CW'(1);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R2: a stopped channel without a counter write holds its count
        p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
            (!start_q[i] && !wr_count[i]) |=> $stable(count_v[i]));

        // R3: a running nonzero count moves by at most one per cycle
        p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
            (start_q[i] && !wr_count[i] && count_v[i] != '0) |=>
            (count_v[i] == $past(count_v[i]) || count_v[i] == $past(count_v[i]) - ONE));

        // R4: when the flag rises the counter holds the reload value
        p_reload_on_flag_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_v[i]) |-> (count_v[i] == $past(reload_v[i])));

        // R6: the flag rises only from a running channel at zero
        p_flag_source_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_v[i]) |-> ($past(start_q[i]) && $past(count_v[i]) == '0));
    end
endmodule

bind ptmr_top ptmr_checker #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_q  (start_q),
    .count_v  (count_v),
    .reload_v (reload_v),
    .flag_v   (flag_v),
    .wr_count (wr_count)
);

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
    localparam int CLK_P = 10;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [2:0] run_sh = '0;

    ptmr_top u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] ra(input int ch, input int sel);
        return 4'((ch + 1) * 4 + sel);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_run(input int ch, input logic v);
        run_sh[ch] = v;
        wr(4'd0, {29'd0, run_sh});
    endtask

    task automatic wait_irq(input int ch, input int limit, output int t);
        int n = 0;
        while (!irq[ch] && n < limit) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
        if (!irq[ch]) begin
            errors++;
            checks++;
            $display("FAIL irq wait ch%0d actual=0 expected=1", ch);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); check("R1 run reg", d, 0);
        for (int c = 0; c < 3; c++) begin
            rd(ra(c, 0), d); check("R1 reload", d, 32'hFFFF_FFFF);
            rd(ra(c, 1), d); check("R1 count", d, 32'hFFFF_FFFF);
            rd(ra(c, 2), d); check("R1 ctrl", d, 0);
        end
        check("R1 irq", {29'd0, irq}, 0);
    endtask

    task automatic t_period(input int ch, input int sel, input int c);
        logic [31:0] d;
        int t1, t2, div;
        div = 4 << (2 * sel);
        set_run(ch, 1'b0);
        wr(ra(ch, 0), c);
        wr(ra(ch, 1), c);
        wr(ra(ch, 2), 32'(sel) | 32'h8);
        set_run(ch, 1'b1);
        wait_irq(ch, div * (c + 2) + 8, t1);
        rd(ra(ch, 1), d); check("R4 reload same cycle", d, c);
        rd(ra(ch, 2), d); check("R4 flag set", {31'd0, d[4]}, 1);
        wr(ra(ch, 2), 32'(sel) | 32'h8);
        #1; check("R5 irq low after clear", {31'd0, irq[ch]}, 0);
        wait_irq(ch, div * (c + 2) + 8, t2);
        check("R3 underflow period", t2 - t1, div * (c + 1));
        set_run(ch, 1'b0);
        wr(ra(ch, 2), 32'h0);
    endtask

    task automatic t_flag();
        logic [31:0] d;
        int t;
        wr(ra(0, 2), 32'h18);
        rd(ra(0, 2), d); check("R6 write one does not set", d, 32'h08);
        check("R6 irq stays low", {31'd0, irq[0]}, 0);
        wr(ra(0, 0), 0);
        wr(ra(0, 1), 0);
        set_run(0, 1'b1);
        wait_irq(0, 20, t);
        set_run(0, 1'b0);
        wr(ra(0, 2), 32'h10);
        rd(ra(0, 2), d); check("R6 write one keeps flag", d, 32'h10);
        check("R5 flag without enable", {31'd0, irq[0]}, 0);
        wr(ra(0, 2), 32'h18);
        #1; check("R5 flag with enable", {31'd0, irq[0]}, 1);
        wr(ra(0, 2), 32'h08);
        rd(ra(0, 2), d); check("R6 write zero clears", d, 32'h08);
        check("R6 irq low after clear", {31'd0, irq[0]}, 0);
        wr(ra(0, 2), 32'h0);
    endtask

    task automatic t_pause();
        logic [31:0] v1, v2, v3;
        int t;
        wr(ra(1, 0), 1000);
        wr(ra(1, 1), 1000);
        wr(ra(1, 2), 0);
        set_run(1, 1'b1);
        repeat (40) @(negedge clk);
        rd(ra(1, 1), v1); check("R2 running moves", {31'd0, v1 < 1000}, 1);
        set_run(1, 1'b0);
        rd(ra(1, 1), v2);
        wr(ra(0, 0), 3); wr(ra(0, 1), 3); wr(ra(0, 2), 32'h8);
        set_run(0, 1'b1);
        wait_irq(0, 40, t);
        repeat (300) @(negedge clk);
        rd(ra(1, 1), v3); check("R2 stopped holds", v3, v2);
        rd(ra(1, 2), v3); check("R11 other flag untouched", v3, 0);
        check("R11 other irq low", {31'd0, irq[1]}, 0);
        set_run(0, 1'b0);
        wr(ra(0, 2), 0);
    endtask

    task automatic t_deferred();
        logic [31:0] d;
        int t1, t2;
        wr(ra(2, 0), 50);
        wr(ra(2, 1), 20);
        wr(ra(2, 2), 32'h8);
        set_run(2, 1'b1);
        wr(ra(2, 0), 4);
        rd(ra(2, 1), d); check("R7 count undisturbed", {31'd0, d >= 17 && d <= 20}, 1);
        wait_irq(2, 120, t1);
        rd(ra(2, 1), d); check("R7 new reload used", d, 4);
        wr(ra(2, 2), 32'h8);
        wait_irq(2, 40, t2);
        check("R7 new period", t2 - t1, 20);
        wr(ra(2, 2), 32'h8);
        wr(ra(2, 1), 777);
        rd(ra(2, 1), d); check("R8 direct count write", d, 777);
        set_run(2, 1'b0);
        wr(ra(2, 2), 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(ra(1, 2), 32'h7);
        rd(ra(1, 2), d); check("R9 edge bit readback", d, 32'h7);
        wr(ra(1, 2), 32'h0);
        rd(ra(1, 2), d); check("R9 edge bit rising default", {31'd0, d[2]}, 0);
        rd(4'd3, d); check("R10 unmapped addr", d, 0);
        rd(ra(0, 3), d); check("R10 hole in block", d, 0);
        wr(4'd0, 32'hFFFF_FFF8);
        rd(4'd0, d); check("R10 run reg upper bits", d, 0);
        wr(4'd0, 32'h5);
        rd(4'd0, d); check("R10 run reg bits", d, 32'h5);
        wr(4'd0, 32'h0);
        run_sh = '0;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_period(0, 0, 5);
        t_period(1, 1, 2);
        t_period(2, 2, 0);
        t_period(0, 3, 1);
        t_flag();
        t_pause();
        t_deferred();
        t_map();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule